// File: doc/BRIEF.md
# Run-Length Configuration Bit Expander

This block turns a byte stream of compression codes into a serial stream of configuration bits for a downstream bit sink. Each code byte arrives through a valid/ready handshake. The block expands the byte into a run of identical bits, with or without one closing bit of the opposite value. The bits leave one per accepted beat through a second valid/ready handshake.

After every reset the block first sends a fixed 16-bit synchronisation prefix. It accepts no code until the sink has taken that prefix. The code space is split at a threshold of 226:

- Low codes produce runs of ones that end in a zero.
- The code just above the threshold produces a long run of ones with no closing bit.
- Higher codes produce runs of zeros that end in a one.
- The all-ones code produces a lone one.
- Code zero produces nothing.

A last flag that travels with a code is reported on the final bit of that code's expansion.

Top module: `rle_bit_expander`

## Requirements
- R1: After reset the block emits 16 prefix bits, the value 0xFF20 sent most significant bit first. It holds code_ready low until all 16 have been taken, and bit_last stays low on every prefix bit.
- R2: A code n with 1 <= n <= 226 emits n ones followed by one zero.
- R3: Code 227 emits exactly 226 ones and no closing zero.
- R4: A code n with 228 <= n <= 254 emits n - 228 zeros followed by one one, so code 228 emits only a one.
- R5: Code 255 emits a single one.
- R6: Code 0 is consumed without emitting any bit. A last flag given with it produces no bit_last.
- R7: code_ready is high only when no bit of an earlier code, or of the prefix, is still waiting to be taken.
- R8: While bit_valid is high and bit_ready is low, bit_data and bit_last hold their values. Every expansion delivers its exact bit count under any pattern of backpressure.
- R9: bit_last is high only on the final bit of a code that was accepted with code_last high.
- R10: In the first cycle after reset, code_ready is 0, bit_valid is 1, bit_data is 1 and bit_last is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| code_valid | input | 1 | A code byte is offered |
| code_data | input | 8 | Compression code |
| code_last | input | 1 | Marks the final code of a stream |
| code_ready | output | 1 | Block takes the offered code this cycle |
| bit_valid | output | 1 | An output bit is offered |
| bit_data | output | 1 | Output configuration bit |
| bit_last | output | 1 | Final bit of a code flagged last |
| bit_ready | input | 1 | Sink takes the offered bit this cycle |

## Verification
Two events can coincide here: the transfer of the final prefix bit, and the acceptance of a code that has been waiting since reset. The bench raises code_valid before the prefix starts and holds it through all 16 prefix beats while the sink stalls on every third cycle. It checks that code_ready stays low until the sixteenth bit has been taken. The waiting code must then expand to the correct pattern, with no prefix bit lost or repeated. A second overlap is a sink stall on the final bit of a run that carries bit_last. There the bench checks that both the bit and the flag survive the stall and that the next code is not taken early.

// File: rtl/rle_pkg.sv
// Shared constants and types for the run-length bit expander.
// Assumes 8-bit code bytes; the threshold and prefix are top-level parameters.
package rle_pkg;
    localparam int CODE_W = 8;

    // Expansion plan for one code: a run, then an optional closing bit.
    typedef struct packed {
        logic [CODE_W-1:0] run_len;
        logic              run_bit;
        logic              has_tail;
        logic              tail_bit;
    } run_plan_t;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_RUN  = 2'd1,
        ENG_TAIL = 2'd2
    } eng_state_t;
endpackage

// File: rtl/rle_code_decoder.sv
// Combinational code classifier: maps one code byte to a run length, the run
// value and an optional closing bit. Assumes MAX_ONES + 2 < 2**CODE_W - 1.
module rle_code_decoder
    import rle_pkg::*;
#(
    parameter int MAX_ONES = 226
) (
    input  logic [CODE_W-1:0] code,
    output run_plan_t         plan
);
    localparam logic [CODE_W-1:0] ONES_TOP  = CODE_W'(MAX_ONES);
    localparam logic [CODE_W-1:0] LONG_CODE = CODE_W'(MAX_ONES + 1);
    localparam logic [CODE_W-1:0] ZERO_BASE = CODE_W'(MAX_ONES + 2);
    localparam logic [CODE_W-1:0] FULL_CODE = {CODE_W{1'b1}};

    // Classify the code into one of the five expansion kinds.
    always_comb begin
        plan = '0;
        if (code == '0) begin
            plan = '0;
        end else if (code <= ONES_TOP) begin
            plan.run_len  = code;
            plan.run_bit  = 1'b1;
            plan.has_tail = 1'b1;
            plan.tail_bit = 1'b0;
        end else if (code == LONG_CODE) begin
            plan.run_len  = ONES_TOP;
            plan.run_bit  = 1'b1;
        end else if (code == FULL_CODE) begin
            plan.has_tail = 1'b1;
            plan.tail_bit = 1'b1;
        end else begin
            plan.run_len  = code - ZERO_BASE;
            plan.run_bit  = 1'b0;
            plan.has_tail = 1'b1;
            plan.tail_bit = 1'b1;
        end
    end
endmodule

// File: rtl/rle_sync_source.sv
// Emits a fixed prefix word MSB first, one bit per take, once per reset.
// Assumes take is asserted only while valid is high.
module rle_sync_source #(
    parameter int              SYNC_W    = 16,
    parameter logic [SYNC_W-1:0] SYNC_WORD = 16'hFF20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    output logic valid,
    output logic bit_o,
    output logic done
);
    localparam int IDX_W = $clog2(SYNC_W + 1);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(SYNC_W);

    logic [SYNC_W-1:0] shreg;
    logic [IDX_W-1:0]  sent;

    // Shift out one prefix bit per take and count how many have left.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= SYNC_WORD;
            sent  <= '0;
        end else if (take) begin
            shreg <= {shreg[SYNC_W-2:0], 1'b0};
            sent  <= sent + 1'b1;
        end
    end

    // Present the current prefix bit until all have been sent.
    always_comb begin
        valid = (sent != IDX_END);
        done  = ~valid;
        bit_o = shreg[SYNC_W-1];
    end
endmodule

// File: rtl/rle_run_engine.sv
// Holds one decoded plan and emits its run then its closing bit.
// Assumes load is asserted only while idle is high and take only while valid.
module rle_run_engine
    import rle_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  run_plan_t plan,
    input  logic      last_in,
    input  logic      take,
    output logic      idle,
    output logic      valid,
    output logic      bit_o,
    output logic      last_o
);
    eng_state_t        state;
    run_plan_t         plan_q;
    logic              last_q;
    logic [CODE_W-1:0] remain;

    // Step through the run count, then the optional closing bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ENG_IDLE;
            plan_q <= '0;
            last_q <= 1'b0;
            remain <= '0;
        end else begin
            case (state)
                ENG_IDLE: if (load) begin
                    plan_q <= plan;
                    last_q <= last_in;
                    remain <= plan.run_len;
                    if (plan.run_len != '0)  state <= ENG_RUN;
                    else if (plan.has_tail)  state <= ENG_TAIL;
                    else                     state <= ENG_IDLE;
                end
                ENG_RUN: if (take) begin
                    remain <= remain - 1'b1;
                    if (remain == CODE_W'(1))
                        state <= plan_q.has_tail ? ENG_TAIL : ENG_IDLE;
                end
                ENG_TAIL: if (take) state <= ENG_IDLE;
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // Drive the current bit and mark the final bit of a flagged code.
    always_comb begin
        idle   = (state == ENG_IDLE);
        valid  = ~idle;
        bit_o  = (state == ENG_RUN) ? plan_q.run_bit : plan_q.tail_bit;
        last_o = last_q && ((state == ENG_TAIL) ||
                 ((state == ENG_RUN) && (remain == CODE_W'(1)) && !plan_q.has_tail));
    end
endmodule

// File: rtl/rle_bit_expander.sv
// Top: sends the sync prefix, then expands each accepted code into bits.
// Assumes the sink honours valid/ready; codes are taken only when fully idle.
module rle_bit_expander
    import rle_pkg::*;
#(
    parameter int              MAX_ONES  = 226,
    parameter int              SYNC_W    = 16,
    parameter logic [SYNC_W-1:0] SYNC_WORD = 16'hFF20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_valid,
    input  logic [CODE_W-1:0] code_data,
    input  logic              code_last,
    output logic              code_ready,
    output logic              bit_valid,
    output logic              bit_data,
    output logic              bit_last,
    input  logic              bit_ready
);
    run_plan_t plan;
    logic sync_valid, sync_bit, sync_done, sync_take;
    logic eng_idle, eng_valid, eng_bit, eng_last, eng_take, eng_load;

    rle_code_decoder #(.MAX_ONES(MAX_ONES)) u_dec (
        .code (code_data),
        .plan (plan)
    );

    rle_sync_source #(.SYNC_W(SYNC_W), .SYNC_WORD(SYNC_WORD)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (sync_take),
        .valid (sync_valid),
        .bit_o (sync_bit),
        .done  (sync_done)
    );

    rle_run_engine u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (eng_load),
        .plan    (plan),
        .last_in (code_last),
        .take    (eng_take),
        .idle    (eng_idle),
        .valid   (eng_valid),
        .bit_o   (eng_bit),
        .last_o  (eng_last)
    );

    // Route the prefix first, then the engine, onto the bit port.
    always_comb begin
        sync_take  = sync_valid & bit_ready;
        eng_take   = eng_valid & bit_ready;
        code_ready = sync_done & eng_idle;
        eng_load   = code_valid & code_ready;
        bit_valid  = sync_valid | eng_valid;
        bit_data   = sync_valid ? sync_bit : eng_bit;
        bit_last   = ~sync_valid & eng_last;
    end
endmodule

// File: rtl/rle_bit_expander_chk.sv
// Property checker for rle_bit_expander, attached by bind below.
// Counts prefix handshakes itself to judge when codes may be taken.
module rle_bit_expander_chk #(
    parameter int SYNC_W = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       code_valid,
    input logic [7:0] code_data,
    input logic       code_last,
    input logic       code_ready,
    input logic       bit_valid,
    input logic       bit_data,
    input logic       bit_last,
    input logic       bit_ready
);
    int unsigned seen;

    // Count handshaked bits up to the prefix length.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 0;
        else if (bit_valid && bit_ready && seen < SYNC_W) seen <= seen + 1;
    end

    a_r1_prefix_first: assert property (@(posedge clk) disable iff (!rst_n)
        code_ready |-> (seen == SYNC_W));
    a_r7_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        code_ready |-> !bit_valid);
    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && !bit_ready) |=> (bit_valid && $stable(bit_data) && $stable(bit_last)));
    a_r9_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        bit_last |-> bit_valid);
    a_r6_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && code_ready && code_data == 8'd0) |=> (!bit_valid && code_ready));
    a_r2_ones_start: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && code_ready && code_data != 8'd0 && code_data <= 8'd226)
        |=> (bit_valid && bit_data));
    a_r5_full_single: assert property (@(posedge clk) disable iff (!rst_n)
        (code_valid && code_ready && code_data == 8'd255)
        |=> (bit_valid && bit_data && (bit_last == $past(code_last))));
endmodule

bind rle_bit_expander rle_bit_expander_chk #(.SYNC_W(SYNC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_valid (code_valid),
    .code_data  (code_data),
    .code_last  (code_last),
    .code_ready (code_ready),
    .bit_valid  (bit_valid),
    .bit_data   (bit_data),
    .bit_last   (bit_last),
    .bit_ready  (bit_ready)
);

// File: tb/rle_bit_expander_tb.sv
module rle_bit_expander_tb;
    logic       clk = 1'b0;
    logic       rst_n, code_valid, code_last, bit_ready;
    logic [7:0] code_data;
    logic       code_ready, bit_valid, bit_data, bit_last;
    int total = 0, bad = 0, cyc = 0;

    always #5 clk = ~clk;

    rle_bit_expander u_dut (
        .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code_data(code_data),
        .code_last(code_last), .code_ready(code_ready), .bit_valid(bit_valid),
        .bit_data(bit_data), .bit_last(bit_last), .bit_ready(bit_ready)
    );

    // code, bit count, count of ones, final bit value
    localparam int VEC [0:8][0:3] = '{
        '{1,   2,   1,   0},   // R2
        '{5,   6,   5,   0},   // R2
        '{226, 227, 226, 0},   // R2
        '{227, 226, 226, 1},   // R3
        '{228, 1,   1,   1},   // R4
        '{230, 3,   1,   1},   // R4
        '{254, 27,  1,   1},   // R4
        '{255, 1,   1,   1},   // R5
        '{100, 101, 100, 0}    // R2
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] c, input logic l);
        code_valid = 1'b1; code_data = c; code_last = l;
        while (!code_ready) @(negedge clk);
        @(negedge clk);
        code_valid = 1'b0;
    endtask

    task automatic collect(input int limit, output int n, output int ones,
                           output int fin, output int rdy_bad, output int lasts);
        n = 0; ones = 0; fin = -1; rdy_bad = 0; lasts = 0;
        for (int k = 0; k < 3000; k++) begin
            cyc++;
            bit_ready = (cyc % 3) != 0;
            if (bit_valid && code_ready) rdy_bad++;
            if (bit_valid && bit_ready) begin
                n++; ones += int'(bit_data); fin = int'(bit_data);
                if (bit_last) lasts++;
                if (bit_last || n == limit) break;
            end
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n, ones, fin, rdy, lasts;
        logic [15:0] word;
        int early, last_on_prefix;
        rst_n = 1'b0; code_valid = 1'b0; code_data = '0; code_last = 1'b0; bit_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(code_ready == 1'b0, "R10", "reset code_ready", code_ready, 0);
        check(bit_valid == 1'b1,  "R10", "reset bit_valid", bit_valid, 1);
        check(bit_data == 1'b1,   "R10", "reset bit_data", bit_data, 1);
        check(bit_last == 1'b0,   "R10", "reset bit_last", bit_last, 0);

        // R1: a code waits during the whole prefix, with sink stalls.
        code_valid = 1'b1; code_data = 8'd1; code_last = 1'b1;
        word = '0; n = 0; early = 0; last_on_prefix = 0;
        while (n < 16) begin
            cyc++;
            bit_ready = (cyc % 3) != 0;
            if (code_ready) early++;
            if (bit_valid && bit_ready) begin
                word = {word[14:0], bit_data};
                if (bit_last) last_on_prefix++;
                n++;
            end
            @(negedge clk);
        end
        check(word == 16'hFF20, "R1", "prefix word", int'(word), 'hFF20);
        check(early == 0, "R1", "code_ready during prefix", early, 0);
        check(last_on_prefix == 0, "R1", "bit_last on prefix", last_on_prefix, 0);
        while (!code_ready) @(negedge clk);
        @(negedge clk);
        code_valid = 1'b0;
        collect(1000, n, ones, fin, rdy, lasts);
        check(n == 2 && ones == 1 && fin == 0, "R2", "waiting code 1 length", n, 2);

        // Table walk: R2 R3 R4 R5 with backpressure (R8) and readiness (R7).
        for (int v = 0; v < 9; v++) begin
            string tag;
            tag = (VEC[v][0] <= 226) ? "R2" : (VEC[v][0] == 227) ? "R3" :
                  (VEC[v][0] == 255) ? "R5" : "R4";
            send(8'(VEC[v][0]), 1'b1);
            collect(1000, n, ones, fin, rdy, lasts);
            check(n == VEC[v][1], "R8", $sformatf("%s code %0d bit count", tag, VEC[v][0]), n, VEC[v][1]);
            check(ones == VEC[v][2], tag, $sformatf("code %0d ones", VEC[v][0]), ones, VEC[v][2]);
            check(fin == VEC[v][3], tag, $sformatf("code %0d final bit", VEC[v][0]), fin, VEC[v][3]);
            check(rdy == 0, "R7", $sformatf("code_ready with bits pending, code %0d", VEC[v][0]), rdy, 0);
        end

        // R6: code 0 with last flag emits nothing.
        bit_ready = 1'b1;
        send(8'd0, 1'b1);
        early = 0;
        for (int k = 0; k < 5; k++) begin
            if (bit_valid || !code_ready) early++;
            @(negedge clk);
        end
        check(early == 0, "R6", "bits or stall after code 0", early, 0);
        send(8'd255, 1'b1);
        collect(1000, n, ones, fin, rdy, lasts);
        check(n == 1 && ones == 1, "R6", "next code after code 0 length", n, 1);

        // R9: unflagged code gives no bit_last; flagged follower does.
        send(8'd5, 1'b0);
        collect(6, n, ones, fin, rdy, lasts);
        check(lasts == 0, "R9", "bit_last on unflagged code", lasts, 0);
        check(n == 6, "R9", "unflagged code bit count", n, 6);
        send(8'd227, 1'b1);
        collect(1000, n, ones, fin, rdy, lasts);
        check(lasts == 1 && n == 226, "R9", "bit_last on final bit of code 227", n, 226);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule